// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol engine that sits between a two-wire bus (SCL and SDA) and a 256-byte nonvolatile store. It samples both bus lines with the system clock and finds start and stop conditions in the sampled values. It receives the slave address byte and checks it against a fixed selector. When the selector matches, it acknowledges and then does one of two things. On a write it takes a word address and a run of data bytes. On a read it shifts stored bytes out, most significant bit first.

The block owns the 8-bit word address counter. Each received data byte goes out on a one-cycle write strobe with its address. A separate page-write sequencer holds those bytes and starts programming when it sees the commit pulse, which the block raises on the stop condition. While the sequencer reports busy, the engine does not acknowledge its address, so the bus sees a released SDA line. The SDA pad is open-drain and is modelled here by an output enable: when the enable is high, the pad pulls the line low.

Top module: `twowire_mem_slave`

## Requirements
- R1: While reset is held, and afterwards until a transfer addresses the block, `sda_oe` is 0 and `wr_stb` and `commit` stay low.
- R2: A start condition is SDA falling while SCL is high. After it, the first eight bits form the address byte. Bits 7:4 must equal 1010 and bits 3:1 must equal 000. Bit 0 is the direction: 1 means read and 0 means write. If the byte matches and the sequencer is not busy, the block pulls SDA low for the ninth clock. Any other byte gets no acknowledge, and every bit up to the next start condition is ignored.
- R3: On a write transfer, the byte after the address byte is acknowledged and loaded into the word address counter.
- R4: Every data byte of a write transfer is acknowledged. The byte appears on `wr_data` with the counter value on `wr_addr`, qualified by a one-cycle `wr_stb`. The counter then steps by one and wraps from 0xFF to 0x00.
- R5: A stop condition is SDA rising while SCL is high. If the transfer received at least one data byte, the stop produces exactly one cycle of `commit`. Any other stop produces none.
- R6: While `busy_i` is high, the address byte is not acknowledged, SDA stays released, and the rest of that transfer causes no write strobe.
- R7: When the direction bit is 1, the block shifts out the byte at the counter, most significant bit first. It begins on the SCL low phase that follows its acknowledge.
- R8: After each read byte, the counter steps by one, wrapping from 0xFF to 0x00. If the master pulls SDA low on the ninth clock, the next byte follows. If the master leaves SDA high, the block releases SDA until the next start condition.
- R9: A start condition in the middle of a byte abandons that byte without a write strobe and begins a new address reception.
- R10: `sda_oe` changes only while the sampled SCL is low. An acknowledge is therefore held low for the whole high phase of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_i | input | 1 | Page-write sequencer is programming |
| mem_addr | output | 8 | Word address counter, used for reads |
| rd_data | input | 8 | Stored byte at `mem_addr` |
| wr_stb | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 8 | Address of the strobed byte |
| wr_data | output | 8 | Received data byte |
| commit | output | 1 | One-cycle pulse: stop after write data |

## Verification
The bench builds the block with its default selector: device type 1010 and reserved bits 000. It therefore tests both a wrong device type and a nonzero reserved field against that pattern. Because the word address counter is 8 bits wide, crossing from 0xFF to 0x00 on a read and on a write takes only a few bytes. The bench's sequencer stays busy for 600 system clocks after each commit. This is long enough for the next address byte to fall inside the busy window and be refused.

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter logic [2:0] RSV_BITS = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       busy_i,
  output logic [7:0] mem_addr,
  input  logic [7:0] rd_data,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       commit
);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ACKD, S_WADR, S_ACKA, S_WDAT, S_ACKW, S_RDAT, S_RACK, S_RLD
  } st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [7:0] sr, addr;
  logic [3:0] cnt;
  logic       rw, wrote;

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c, byte_in, dev_hit, rx_st;
  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign byte_in  = (cnt == 4'd8);
  assign dev_hit  = (sr[7:1] == {DEV_TYPE, RSV_BITS}) & ~busy_i;
  assign rx_st    = (st == S_DEV) | (st == S_WADR) | (st == S_WDAT);
  assign mem_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy  <= 2'b11;
      sda_sy  <= 2'b11;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      st      <= S_IDLE;
      sr      <= '0;
      addr    <= '0;
      cnt     <= '0;
      rw      <= 1'b0;
      wrote   <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      commit  <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      wr_stb <= 1'b0;
      commit <= 1'b0;
      if (start_c) begin
        st     <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        commit <= wrote;
        wrote  <= 1'b0;
      end else if (scl_rise) begin
        if (rx_st) begin
          sr  <= {sr[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (st == S_RDAT) begin
          cnt <= cnt + 4'd1;
        end else if (st == S_RACK) begin
          addr <= addr + 8'd1;
          st   <= sda_s ? S_IDLE : S_RLD;
        end
      end else if (scl_fall) begin
        case (st)
          S_DEV: if (byte_in) begin
            cnt <= '0;
            if (dev_hit) begin
              sda_oe <= 1'b1;
              rw     <= sr[0];
              st     <= S_ACKD;
            end else begin
              st <= S_IDLE;
            end
          end
          S_ACKD: begin
            cnt <= '0;
            if (rw) begin
              sr     <= rd_data;
              sda_oe <= ~rd_data[7];
              st     <= S_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WADR;
            end
          end
          S_WADR: if (byte_in) begin
            cnt    <= '0;
            addr   <= sr;
            sda_oe <= 1'b1;
            st     <= S_ACKA;
          end
          S_ACKA, S_ACKW: begin
            sda_oe <= 1'b0;
            st     <= S_WDAT;
          end
          S_WDAT: if (byte_in) begin
            cnt     <= '0;
            wr_stb  <= 1'b1;
            wr_addr <= addr;
            wr_data <= sr;
            addr    <= addr + 8'd1;
            wrote   <= 1'b1;
            sda_oe  <= 1'b1;
            st      <= S_ACKW;
          end
          S_RDAT: if (byte_in) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            st     <= S_RACK;
          end else begin
            sr     <= {sr[6:0], 1'b0};
            sda_oe <= ~sr[6];
          end
          S_RLD: begin
            sr     <= rd_data;
            sda_oe <= ~rd_data[7];
            st     <= S_RDAT;
          end
          default: ;
        endcase
      end
    end
  end

  p_ack_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACKD && $past(st) != S_ACKD) |-> $past(sr[7:1] == {DEV_TYPE, RSV_BITS}));

  p_busy_noack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACKD && $past(st) != S_ACKD) |-> !$past(busy_i));

  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_commit_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  p_oe_rise_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  p_rd_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RLD && $past(st) == S_RACK) |-> mem_addr == $past(mem_addr) + 8'd1);

endmodule

// File: tb/twowire_mem_slave_test.sv
module twowire_mem_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl = 1'b1, msda = 1'b1;
  logic busy, sda_oe, wr_stb, commit;
  logic [7:0] mem_addr, wr_addr, wr_data, rd_data;
  logic [7:0] mem [256];
  logic [7:0] model [256];
  logic [15:0] wq[$];
  logic [15:0] eq[$];
  int checks = 0, fails = 0, commits = 0, busy_cnt = 0;

  wire sda_line = msda & ~sda_oe;
  assign rd_data = mem[mem_addr];
  assign busy = (busy_cnt != 0);

  twowire_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .busy_i(busy), .mem_addr(mem_addr), .rd_data(rd_data), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
      busy_cnt <= 0;
      commits  <= 0;
    end else begin
      if (wr_stb) begin
        mem[wr_addr] <= wr_data;
        wq.push_back({wr_addr, wr_data});
      end
      if (commit) begin
        commits  <= commits + 1;
        busy_cnt <= 600;
      end else if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input bit d, input bit exp, input string req, output bit seen);
    int bad = 0;
    int last = 0;
    wait_n(8); msda = d; wait_n(8); scl = 1'b1;
    for (int j = 0; j < 16; j++) begin
      @(negedge clk);
      if (j >= 5 && sda_oe !== exp) begin bad++; last = sda_oe; end
      if (j == 8) seen = sda_line;
    end
    scl = 1'b0;
    chk(bad == 0, req, "SDA drive over SCL high (R10)", bad == 0 ? int'(exp) : last, exp);
  endtask

  task automatic start_c;
    wait_n(8); msda = 1'b1; wait_n(8); scl = 1'b1; wait_n(16); msda = 1'b0; wait_n(16); scl = 1'b0;
  endtask

  task automatic stop_c;
    wait_n(8); msda = 1'b0; wait_n(8); scl = 1'b1; wait_n(16); msda = 1'b1; wait_n(16);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack, input string req);
    bit s;
    for (int i = 7; i >= 0; i--) bitx(b[i], 1'b0, req, s);
    bitx(1'b1, ack, req, s);
  endtask

  task automatic read_byte(input logic [7:0] exp, input bit mack, input string req);
    logic [7:0] got;
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bitx(1'b1, ~exp[i], req, s);
      got[i] = s;
    end
    chk(got == exp, req, "read byte", got, exp);
    bitx(~mack, 1'b0, req, s);
  endtask

  task automatic cmp_writes(input string req);
    chk(wq.size() == eq.size(), req, "write strobe count", wq.size(), eq.size());
    for (int i = 0; i < eq.size() && i < wq.size(); i++)
      chk(wq[i] == eq[i], req, "write addr/data", wq[i], eq[i]);
    wq.delete();
    eq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    bit s;
    for (int i = 0; i < 256; i++) model[i] = 8'(i * 37 + 5);
    wait_n(10);
    chk(!sda_oe && !wr_stb && !commit, "R1", "outputs in reset", {sda_oe, wr_stb, commit}, 0);
    rst_n = 1'b1;
    wait_n(10);
    chk(!sda_oe && !wr_stb && !commit, "R1", "outputs after reset", {sda_oe, wr_stb, commit}, 0);

    // R2: wrong device type, then nonzero reserved bits
    start_c(); send_byte(8'hB0, 1'b0, "R2"); send_byte(8'h10, 1'b0, "R2"); send_byte(8'h66, 1'b0, "R2"); stop_c();
    start_c(); send_byte(8'hA2, 1'b0, "R2"); send_byte(8'h33, 1'b0, "R2"); stop_c();
    cmp_writes("R2");
    chk(commits == 0, "R2", "commit count", commits, 0);

    // R3/R4/R5: two-byte write
    start_c(); send_byte(8'hA0, 1'b1, "R2"); send_byte(8'h10, 1'b1, "R3");
    send_byte(8'h5A, 1'b1, "R4"); send_byte(8'hC3, 1'b1, "R4"); stop_c();
    model[8'h10] = 8'h5A; model[8'h11] = 8'hC3;
    eq.push_back(16'h105A); eq.push_back(16'h11C3);
    cmp_writes("R4");
    chk(commits == 1, "R5", "commit after write data", commits, 1);

    // R6: sequencer busy, address refused and rest ignored
    chk(busy, "R6", "sequencer busy window open", busy, 1);
    start_c(); send_byte(8'hA0, 1'b0, "R6"); send_byte(8'h20, 1'b0, "R6"); send_byte(8'h99, 1'b0, "R6"); stop_c();
    cmp_writes("R6");
    chk(commits == 1, "R6", "no commit while busy", commits, 1);
    wait_n(700);

    // R7/R8: random read with sequential continuation
    start_c(); send_byte(8'hA0, 1'b1, "R3"); send_byte(8'h10, 1'b1, "R3");
    start_c(); send_byte(8'hA1, 1'b1, "R7");
    read_byte(model[8'h10], 1'b1, "R7");
    read_byte(model[8'h11], 1'b1, "R8");
    read_byte(model[8'h12], 1'b0, "R8");
    bitx(1'b1, 1'b0, "R8", s); bitx(1'b0, 1'b0, "R8", s);
    stop_c();
    chk(commits == 1, "R5", "no commit without data byte", commits, 1);

    // R8: counter wrap on read
    start_c(); send_byte(8'hA0, 1'b1, "R3"); send_byte(8'hFE, 1'b1, "R3");
    start_c(); send_byte(8'hA1, 1'b1, "R7");
    read_byte(model[8'hFE], 1'b1, "R8");
    read_byte(model[8'hFF], 1'b1, "R8");
    read_byte(model[8'h00], 1'b0, "R8");
    stop_c();

    // R7: current-address read continues at 0x01
    start_c(); send_byte(8'hA1, 1'b1, "R7"); read_byte(model[8'h01], 1'b0, "R7"); stop_c();

    // R9: restart in the middle of a data byte
    start_c(); send_byte(8'hA0, 1'b1, "R9"); send_byte(8'h40, 1'b1, "R9");
    bitx(1'b1, 1'b0, "R9", s); bitx(1'b0, 1'b0, "R9", s); bitx(1'b1, 1'b0, "R9", s);
    start_c(); send_byte(8'hA1, 1'b1, "R9"); read_byte(model[8'h40], 1'b0, "R9"); stop_c();
    cmp_writes("R9");
    chk(commits == 1, "R9", "no commit after aborted byte", commits, 1);

    // R4: write across the counter wrap, then read back
    start_c(); send_byte(8'hA0, 1'b1, "R4"); send_byte(8'hFF, 1'b1, "R3");
    send_byte(8'h77, 1'b1, "R4"); send_byte(8'h88, 1'b1, "R4"); stop_c();
    model[8'hFF] = 8'h77; model[8'h00] = 8'h88;
    eq.push_back(16'hFF77); eq.push_back(16'h0088);
    cmp_writes("R4");
    chk(commits == 2, "R5", "second commit", commits, 2);
    wait_n(700);
    start_c(); send_byte(8'hA0, 1'b1, "R4"); send_byte(8'hFF, 1'b1, "R4");
    start_c(); send_byte(8'hA1, 1'b1, "R4");
    read_byte(model[8'hFF], 1'b1, "R4"); read_byte(model[8'h00], 1'b0, "R4");
    stop_c();

    wait_n(20);
    finish_up();
  end
endmodule